// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Controller

This block holds the status state that a serial flash device presents to its host. It keeps a busy flag, a write-enable latch, four block-protect bits, a quad-enable bit, a protect-lock bit and a suspend flag. It takes decoded command strobes and a completion pulse from the program/erase sequencer. It returns a 16-bit status word for status reads and a gate, `modify_ok`, that tells the command path whether a program or erase may start.

The core is a four-state machine. In `ST_IDLE` the device is ready. `ST_WRSR` is entered from idle on an accepted status write and returns to idle after the programmed busy time. `ST_OP` is entered from idle on an accepted program or erase. It returns to idle on the sequencer's done pulse and moves to `ST_SUSP` on a suspend strobe during an erase. `ST_SUSP` goes back to `ST_OP` on a resume strobe.

The protect, quad and lock bits stand in for non-volatile storage. They load from `nv_init` during reset.

Top module: `flash_status_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word has busy (bit 0), write-enable (bit 1) and suspend (bit 8) at 0. Bits 5:2 (protect bits 0 to 3) are loaded from `nv_init[3:0]`, bit 6 (quad enable) from `nv_init[4]`, and bit 7 (protect lock) from `nv_init[5]`. `modify_ok` is 0.
- R2: In idle, an accepted write-enable strobe sets bit 1 on the next cycle. An accepted write-disable strobe clears it on the next cycle.
- R3: `modify_ok` is 1 exactly when the device is idle and bit 1 is 1. A program or erase strobe while `modify_ok` is 0 leaves bit 0 at 0.
- R4: An accepted program, sector, block or chip erase sets bit 0 on the next cycle. Bits 0 and 1 stay 1 until `seq_done`, and both read 0 in the cycle after it.
- R5: A status write is accepted only when bit 1 is 1. It loads bit 6 from `wrsr_data[6]` and bit 7 from `wrsr_data[7]`. It loads bits 5:2 from `wrsr_data[5:2]` only if bit 7 was 0 before the write. With bit 1 at 0, the status write changes nothing.
- R6: After an accepted status write, bit 0 reads 1 for `wrsr_cycles` cycles, or for 1 cycle when `wrsr_cycles` is 0. In the next cycle, bits 0 and 1 read 0 together.
- R7: While bit 0 is 1, the write-enable, write-disable, status-write, program and erase strobes are ignored.
- R8: A suspend strobe during an erase sets bit 8 and makes bit 0 read 0, with `modify_ok` at 0. While suspended, every strobe except resume is ignored. Resume clears bit 8 and sets bit 0 again. A suspend during a program is ignored.
- R9: When `seq_done` and a suspend strobe fall in the same cycle of an erase, the completion wins: bits 0, 1 and 8 all read 0 on the next cycle.
- R10: When several strobes arrive together in idle, exactly one is taken. The order of precedence is program/erase (only if bit 1 is 1), then status write (only if bit 1 is 1), then write disable, then write enable.
- R11: Bits 15:9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_init | input | 6 | Stored values of the non-volatile bits: [3:0] protect, [4] quad enable, [5] protect lock |
| wrsr_cycles | input | CNT_W | Busy time of a status write, in cycles |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Byte written by a status write |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_serase | input | 1 | Sector-erase strobe |
| cmd_berase | input | 1 | Block-erase strobe |
| cmd_cerase | input | 1 | Chip-erase strobe |
| seq_done | input | 1 | Completion pulse from the program/erase sequencer |
| cmd_suspend | input | 1 | Erase-suspend strobe |
| cmd_resume | input | 1 | Erase-resume strobe |
| status_word | output | 16 | Status word returned to status reads |
| modify_ok | output | 1 | Gate: a program or erase may start this cycle |

## Verification
The sequencer's done pulse and a suspend strobe can land in the same cycle of an erase. The bench drives both in one cycle during a sector erase and expects busy, write-enable and suspend all to read 0 afterwards. The second collision is several strobes in one idle cycle. The bench presents write enable with write disable, and program with status write. It judges the precedence order from the status word and gate sampled in the following cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WRSR = 2'd1,
        ST_OP   = 2'd2,
        ST_SUSP = 2'd3
    } fsr_state_e;

    localparam int unsigned STAT_W  = 16;
    localparam int unsigned BP_W    = 4;
    localparam int unsigned NV_W    = BP_W + 2;
    localparam int unsigned B_BUSY  = 0;
    localparam int unsigned B_WEL   = 1;
    localparam int unsigned B_BP0   = 2;
    localparam int unsigned B_QE    = B_BP0 + BP_W;
    localparam int unsigned B_BPL   = B_QE + 1;
    localparam int unsigned B_SUS   = 8;
    localparam int unsigned RSV_LO  = B_SUS + 1;

    typedef struct packed {
        logic            bpl;
        logic            qe;
        logic [BP_W-1:0] bp;
    } nv_bits_t;

endpackage

// File: rtl/fsr_fsm.sv
module fsr_fsm
    import fsr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wrsr_cycles,
    input  logic             wel,
    input  logic             cmd_wren,
    input  logic             cmd_wrdi,
    input  logic             cmd_wrsr,
    input  logic             cmd_prog,
    input  logic             cmd_serase,
    input  logic             cmd_berase,
    input  logic             cmd_cerase,
    input  logic             seq_done,
    input  logic             cmd_suspend,
    input  logic             cmd_resume,
    output logic             acc_op,
    output logic             acc_wrsr,
    output logic             acc_wrdi,
    output logic             acc_wren,
    output logic             wel_clear,
    output logic             busy,
    output logic             sus,
    output logic             idle,
    output logic             op_busy
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    fsr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              erase_q;
    logic              any_erase;
    logic              any_op;
    logic              wrsr_last;

    assign any_erase = cmd_serase | cmd_berase | cmd_cerase;
    assign any_op    = cmd_prog | any_erase;
    assign wrsr_last = (cnt_q == CNT_ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_op && wel) begin
                    state_d = ST_OP;
                end else if (cmd_wrsr && wel) begin
                    state_d = ST_WRSR;
                end
            end
            ST_WRSR: begin
                if (wrsr_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_OP: begin
                if (seq_done) begin
                    state_d = ST_IDLE;
                end else if (cmd_suspend && erase_q) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (cmd_resume) begin
                    state_d = ST_OP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        acc_op    = 1'b0;
        acc_wrsr  = 1'b0;
        acc_wrdi  = 1'b0;
        acc_wren  = 1'b0;
        wel_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_op && wel) begin
                    acc_op = 1'b1;
                end else if (cmd_wrsr && wel) begin
                    acc_wrsr = 1'b1;
                end else if (cmd_wrdi) begin
                    acc_wrdi = 1'b1;
                end else if (cmd_wren) begin
                    acc_wren = 1'b1;
                end
            end
            ST_WRSR: wel_clear = wrsr_last;
            ST_OP:   wel_clear = seq_done;
            ST_SUSP: wel_clear = 1'b0;
            default: wel_clear = 1'b0;
        endcase
    end

    // Status-write busy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (acc_wrsr) begin
            cnt_q <= (wrsr_cycles == '0) ? CNT_ONE : wrsr_cycles;
        end else if (state_q == ST_WRSR && !wrsr_last) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Kind of the running operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q <= 1'b0;
        end else if (acc_op) begin
            erase_q <= any_erase;
        end
    end

    assign busy    = (state_q == ST_WRSR) || (state_q == ST_OP);
    assign op_busy = (state_q == ST_OP);
    assign sus     = (state_q == ST_SUSP);
    assign idle    = (state_q == ST_IDLE);

endmodule

// File: rtl/fsr_wel.sv
module fsr_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (clr_i) begin
            wel_o <= 1'b0;
        end else if (set_i) begin
            wel_o <= 1'b1;
        end
    end

endmodule

// File: rtl/fsr_nvbits.sv
module fsr_nvbits
    import fsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  nv_bits_t init_i,
    input  logic     wr_i,
    input  logic [7:0] data_i,
    output nv_bits_t bits_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_o.qe  <= init_i.qe;
            bits_o.bpl <= init_i.bpl;
        end else if (wr_i) begin
            bits_o.qe  <= data_i[B_QE];
            bits_o.bpl <= data_i[B_BPL];
        end
    end

    for (genvar gi = 0; gi < BP_W; gi++) begin : g_bp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_o.bp[gi] <= init_i.bp[gi];
            end else if (wr_i && !bits_o.bpl) begin
                bits_o.bp[gi] <= data_i[B_BP0+gi];
            end
        end
    end

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        nv_init,
    input  logic [CNT_W-1:0]  wrsr_cycles,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_prog,
    input  logic              cmd_serase,
    input  logic              cmd_berase,
    input  logic              cmd_cerase,
    input  logic              seq_done,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    output logic [15:0]       status_word,
    output logic              modify_ok
);

    logic     acc_op, acc_wrsr, acc_wrdi, acc_wren, wel_clear;
    logic     busy, sus, idle, op_busy, wel;
    nv_bits_t nv_q;
    nv_bits_t nv_init_s;

    assign nv_init_s = nv_bits_t'(nv_init);

    fsr_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrsr_cycles (wrsr_cycles),
        .wel         (wel),
        .cmd_wren    (cmd_wren),
        .cmd_wrdi    (cmd_wrdi),
        .cmd_wrsr    (cmd_wrsr),
        .cmd_prog    (cmd_prog),
        .cmd_serase  (cmd_serase),
        .cmd_berase  (cmd_berase),
        .cmd_cerase  (cmd_cerase),
        .seq_done    (seq_done),
        .cmd_suspend (cmd_suspend),
        .cmd_resume  (cmd_resume),
        .acc_op      (acc_op),
        .acc_wrsr    (acc_wrsr),
        .acc_wrdi    (acc_wrdi),
        .acc_wren    (acc_wren),
        .wel_clear   (wel_clear),
        .busy        (busy),
        .sus         (sus),
        .idle        (idle),
        .op_busy     (op_busy)
    );

    fsr_wel i_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (acc_wren),
        .clr_i (acc_wrdi | wel_clear),
        .wel_o (wel)
    );

    fsr_nvbits i_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (nv_init_s),
        .wr_i   (acc_wrsr),
        .data_i (wrsr_data),
        .bits_o (nv_q)
    );

    assign status_word[B_BUSY]            = busy;
    assign status_word[B_WEL]             = wel;
    assign status_word[B_BP0+BP_W-1:B_BP0] = nv_q.bp;
    assign status_word[B_QE]              = nv_q.qe;
    assign status_word[B_BPL]             = nv_q.bpl;
    assign status_word[B_SUS]             = sus;

    for (genvar gr = RSV_LO; gr < STAT_W; gr++) begin : g_rsv
        assign status_word[gr] = 1'b0;
    end

    assign modify_ok = idle & wel;

    logic unused_acc;
    assign unused_acc = acc_op;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wren,
    input logic        cmd_wrdi,
    input logic        cmd_wrsr,
    input logic        cmd_prog,
    input logic        cmd_serase,
    input logic        cmd_berase,
    input logic        cmd_cerase,
    input logic        seq_done,
    input logic [15:0] status_word,
    input logic        modify_ok,
    input logic        op_busy
);

    logic any_op;
    assign any_op = cmd_prog | cmd_serase | cmd_berase | cmd_cerase;

    AST_GATE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        modify_ok |-> (!status_word[0] && status_word[1] && !status_word[8])); // R3

    AST_REFUSE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (any_op && !modify_ok && !status_word[0] && !status_word[8]) |=> !status_word[0]); // R3

    AST_WEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !cmd_wrsr && !any_op && !status_word[0] && !status_word[8])
        |=> status_word[1]); // R2

    AST_BUSY_HAS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[0] |-> status_word[1]); // R4

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && seq_done) |=> (!status_word[0] && !status_word[1])); // R4

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7] |=> $stable(status_word[5:2])); // R5

    AST_SUS_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[8] |-> (!status_word[0] && !modify_ok)); // R8

endmodule

bind flash_status_ctrl fsr_checker i_fsr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_prog    (cmd_prog),
    .cmd_serase  (cmd_serase),
    .cmd_berase  (cmd_berase),
    .cmd_cerase  (cmd_cerase),
    .seq_done    (seq_done),
    .status_word (status_word),
    .modify_ok   (modify_ok),
    .op_busy     (op_busy)
);

// File: tb/test_flash_status_ctrl.sv
`timescale 1ns/1ps
module test_flash_status_ctrl;

    localparam int CNT_W = 8;

    localparam logic [9:0] S_NONE = 10'd0;
    localparam logic [9:0] S_WREN = 10'd1 << 0;
    localparam logic [9:0] S_WRDI = 10'd1 << 1;
    localparam logic [9:0] S_WRSR = 10'd1 << 2;
    localparam logic [9:0] S_PROG = 10'd1 << 3;
    localparam logic [9:0] S_SERA = 10'd1 << 4;
    localparam logic [9:0] S_BERA = 10'd1 << 5;
    localparam logic [9:0] S_CERA = 10'd1 << 6;
    localparam logic [9:0] S_DONE = 10'd1 << 7;
    localparam logic [9:0] S_SUSP = 10'd1 << 8;
    localparam logic [9:0] S_RESM = 10'd1 << 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       nv_init = 6'd0;
    logic [CNT_W-1:0] wrsr_cycles = 8'd3;
    logic [9:0]       strb = '0;
    logic [7:0]       wrsr_data = 8'd0;
    logic [15:0]      status_word;
    logic             modify_ok;

    typedef struct {
        logic [15:0] st;
        logic        ok;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done_flag = 1'b0;

    always #2 clk = ~clk;

    flash_status_ctrl #(.CNT_W(CNT_W)) i_flash_status_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_init     (nv_init),
        .wrsr_cycles (wrsr_cycles),
        .cmd_wren    (strb[0]),
        .cmd_wrdi    (strb[1]),
        .cmd_wrsr    (strb[2]),
        .wrsr_data   (wrsr_data),
        .cmd_prog    (strb[3]),
        .cmd_serase  (strb[4]),
        .cmd_berase  (strb[5]),
        .cmd_cerase  (strb[6]),
        .seq_done    (strb[7]),
        .cmd_suspend (strb[8]),
        .cmd_resume  (strb[9]),
        .status_word (status_word),
        .modify_ok   (modify_ok)
    );

    // Driver: one cycle of stimulus plus the result expected after the edge
    task automatic cyc(input logic [9:0] s, input logic [7:0] d,
                       input logic [15:0] es, input logic eo, input string tag);
        @(negedge clk);
        strb      = s;
        wrsr_data = d;
        exp_q.push_back('{st: es, ok: eo, tag: tag});
    endtask

    task automatic hold_reset(input logic [5:0] init);
        @(negedge clk);
        strb    = '0;
        nv_init = init;
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops one expected item per clock edge that has one pending
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (status_word !== e.st || modify_ok !== e.ok) begin
                    errors++;
                    $display("FAIL %s: status=%h ok=%b expected status=%h ok=%b",
                             e.tag, status_word, modify_ok, e.st, e.ok);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state with all stored bits clear
        checks++;
        #1;
        if (status_word !== 16'h0000 || modify_ok !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: status=%h ok=%b expected status=0000 ok=0",
                     status_word, modify_ok);
        end
        hold_reset(6'd0);
        cyc(S_NONE, 8'h00, 16'h0000, 1'b0, "R1 after reset, R11 reserved");
        cyc(S_PROG, 8'h00, 16'h0000, 1'b0, "R3 program refused without WEL");
        cyc(S_WRSR, 8'hFF, 16'h0000, 1'b0, "R5 status write refused without WEL");
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 write enable");
        cyc(S_WRDI, 8'h00, 16'h0000, 1'b0, "R2 write disable");
        cyc(S_WREN | S_WRDI, 8'h00, 16'h0000, 1'b0, "R10 disable beats enable");
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable again");
        cyc(S_PROG | S_WRSR, 8'hFF, 16'h0003, 1'b0, "R10 program beats status write");
        cyc(S_WREN | S_WRDI | S_WRSR | S_CERA, 8'hFF, 16'h0003, 1'b0, "R7 strobes ignored when busy");
        cyc(S_NONE, 8'h00, 16'h0003, 1'b0, "R4 busy holds");
        cyc(S_DONE, 8'h00, 16'h0000, 1'b0, "R4 done clears busy and WEL");

        // Status writes, busy time 3
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable");
        cyc(S_WRSR, 8'h54, 16'h0057, 1'b0, "R5 write BP=0101 QE=1");
        cyc(S_NONE, 8'h00, 16'h0057, 1'b0, "R6 busy cycle 2");
        cyc(S_NONE, 8'h00, 16'h0057, 1'b0, "R6 busy cycle 3");
        cyc(S_NONE, 8'h00, 16'h0054, 1'b0, "R6 busy and WEL cleared");
        cyc(S_WREN, 8'h00, 16'h0056, 1'b1, "R2 enable");
        cyc(S_WRSR, 8'hBC, 16'h00BF, 1'b0, "R5 write BP=1111 lock on");
        cyc(S_NONE, 8'h00, 16'h00BF, 1'b0, "R6 busy");
        cyc(S_NONE, 8'h00, 16'h00BF, 1'b0, "R6 busy");
        cyc(S_NONE, 8'h00, 16'h00BC, 1'b0, "R6 done");
        cyc(S_WREN, 8'h00, 16'h00BE, 1'b1, "R2 enable");
        cyc(S_WRSR, 8'h40, 16'h007F, 1'b0, "R5 locked BP kept, lock and QE written");
        cyc(S_NONE, 8'h00, 16'h007F, 1'b0, "R6 busy");
        cyc(S_NONE, 8'h00, 16'h007F, 1'b0, "R6 busy");
        cyc(S_NONE, 8'h00, 16'h007C, 1'b0, "R6 done");
        @(negedge clk);
        wrsr_cycles = 8'd0;
        cyc(S_WREN, 8'h00, 16'h007E, 1'b1, "R2 enable");
        cyc(S_WRSR, 8'h00, 16'h0003, 1'b0, "R5 unlocked write clears BP");
        cyc(S_NONE, 8'h00, 16'h0000, 1'b0, "R6 zero count busy one cycle");

        // Erase suspend and resume
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable");
        cyc(S_SERA, 8'h00, 16'h0003, 1'b0, "R4 sector erase busy");
        cyc(S_SUSP, 8'h00, 16'h0102, 1'b0, "R8 suspended, busy reads 0");
        cyc(S_WRDI | S_PROG, 8'h00, 16'h0102, 1'b0, "R8 strobes ignored while suspended");
        cyc(S_DONE, 8'h00, 16'h0102, 1'b0, "R8 done ignored while suspended");
        cyc(S_RESM, 8'h00, 16'h0003, 1'b0, "R8 resume");
        cyc(S_DONE | S_SUSP, 8'h00, 16'h0000, 1'b0, "R9 done beats suspend");
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable");
        cyc(S_PROG, 8'h00, 16'h0003, 1'b0, "R4 program busy");
        cyc(S_SUSP, 8'h00, 16'h0003, 1'b0, "R8 suspend ignored in program");
        cyc(S_DONE, 8'h00, 16'h0000, 1'b0, "R4 program done");
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable");
        cyc(S_CERA, 8'h00, 16'h0003, 1'b0, "R4 chip erase busy");
        cyc(S_DONE, 8'h00, 16'h0000, 1'b0, "R4 chip erase done");
        cyc(S_WREN, 8'h00, 16'h0002, 1'b1, "R2 enable");
        cyc(S_BERA, 8'h00, 16'h0003, 1'b0, "R4 block erase busy");
        cyc(S_DONE, 8'h00, 16'h0000, 1'b0, "R4 block erase done");

        // Reset with stored bits: BP=1010, QE=0, lock=1
        hold_reset(6'b10_1010);
        cyc(S_NONE, 8'h00, 16'h00A8, 1'b0, "R1 stored bits reload");
        cyc(S_WREN, 8'h00, 16'h00AA, 1'b1, "R2 enable");
        cyc(S_WRSR, 8'h00, 16'h002B, 1'b0, "R5 lock from reset keeps BP");
        cyc(S_NONE, 8'h00, 16'h0028, 1'b0, "R6 done");

        @(negedge clk);
        strb = '0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule